// File: doc/BRIEF.md
# Dual Countdown Timer

A register-mapped unit holding two independent down-counting timers. Each timer has a divisor register, a live count register and a control register. A control word carries a 2-bit operation code and a 3-bit tick-source code. The operation code can load the divisor into the counter, freeze the counter, or let it count. The tick-source code picks one of four external tick-enable inputs, or no source at all. A running timer decrements once per pulse on its selected tick. It reloads from the divisor when it expires, so it repeats at a fixed period.

Each expiry sets a timer-specific bit in a shared status register. A mask register gates those bits onto a single level interrupt line. Software clears the bits through a write-one-to-clear acknowledge register. The register bus is a single-cycle 32-bit word interface: one write strobe and a combinational read path.

Top module: `dual_timer`

## Requirements
- R1: After reset both counts, divisors, control words, the status and the mask read zero, both timers are stopped, and `irq_o` is low.
- R2: A control write with bits [1:0] = 0 (load) copies that timer's divisor into its counter. A divisor write alone leaves the counter unchanged.
- R3: With bits [1:0] = 2 (run), the counter decrements by one on each cycle where its selected tick is high. Tick-source codes 4, 5, 6 and 7 in control bits [4:2] select `tick_i[0]`, `tick_i[1]`, `tick_i[2]` and `tick_i[3]`.
- R4: With bits [1:0] = 1 (hold), the counter keeps its value whatever the tick inputs do.
- R5: Tick-source codes 0 to 3 produce no counting, even in run.
- R6: A control write with bits [1:0] = 3 is discarded. The stored control word, the run state and the counter do not change.
- R7: A tick that finds the counter at 1 or 0 reloads the divisor instead of decrementing. It also sets the timer's status bit (timer0 sets bit 0, timer1 sets bit 1). No status bit rises without a tick.
- R8: A write to the acknowledge offset 0x4C clears each status bit written as 1 and leaves the others set. The offset reads zero.
- R9: The mask at 0x48 reads back as written, and the masked status at 0x54 equals raw status (0x50) AND mask.
- R10: `irq_o` is high exactly when raw status AND mask is nonzero. It reflects a mask or acknowledge write from the next cycle.
- R11: Reads of unmapped offsets return zero. Writes to unmapped offsets, and to the read-only status views, change nothing.
- R12: A load arriving in the same cycle as a tick wins: the counter takes the divisor and nothing expires.
- R13: An expiry in the same cycle as an acknowledge of the same bit leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| tick_i | input | 4 | Tick-enable pulses for source codes 4..7 |
| irq_o | output | 1 | Level interrupt, high while masked status is nonzero |

## Verification
The bench builds the block with its default parameters: two timers, 32-bit registers, four tick sources and an 8-bit offset space. At these values the bench can reach the fixed register map and both status bits. Small divisors let an expiry happen within a few tick pulses. This makes it cheap to drive a tick into the same cycle as a load or an acknowledge, which settles the priority rules.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmr_op_e;

  localparam int SRC_W     = 3;
  localparam int SRC_FIRST = 4;
  localparam int CTRL_W    = SRC_W + 2;

  localparam int TMR_STRIDE = 16;
  localparam int OFS_DIV    = 'h00;
  localparam int OFS_CNT    = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_MASK   = 'h48;
  localparam int OFS_ACK    = 'h4C;
  localparam int OFS_STAT   = 'h50;
  localparam int OFS_MSTAT  = 'h54;

endpackage

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_TICK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] div_wdata_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [N_TICK-1:0] tick_i,
  output logic [DATA_W-1:0] div_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              expire_o
);

  logic [DATA_W-1:0] div_q, cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              run_q;
  logic [SRC_W-1:0]  src_q;
  tmr_op_e           op_w;
  logic              ctrl_ok, do_load, tick_sel, step, at_end;

  assign op_w    = tmr_op_e'(ctrl_wdata_i[1:0]);
  assign ctrl_ok = ctrl_we_i && (op_w != OP_BAD);
  assign do_load = ctrl_ok && (op_w == OP_LOAD);
  assign src_q   = ctrl_q[CTRL_W-1:2];

  always_comb begin
    tick_sel = 1'b0;
    for (int k = 0; k < N_TICK; k++) begin
      if (src_q == SRC_W'(SRC_FIRST + k)) tick_sel = tick_i[k];
    end
  end

  // load in the same cycle beats a tick
  assign step   = run_q && tick_sel && !do_load;
  assign at_end = (cnt_q <= DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      ctrl_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (div_we_i) div_q <= div_wdata_i;
      if (ctrl_ok) begin
        ctrl_q <= ctrl_wdata_i;
        if (op_w == OP_HOLD) run_q <= 1'b0;
        if (op_w == OP_RUN)  run_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (do_load) begin
      cnt_q <= div_q;
    end else if (step) begin
      cnt_q <= at_end ? div_q : cnt_q - DATA_W'(1);
    end
  end

  assign div_o    = div_q;
  assign cnt_o    = cnt_q;
  assign ctrl_o   = ctrl_q;
  assign expire_o = step && at_end;

endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
  parameter int NUM_TMR = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_TMR-1:0] mask_wdata_i,
  input  logic               ack_we_i,
  input  logic [NUM_TMR-1:0] ack_wdata_i,
  input  logic [NUM_TMR-1:0] expire_i,
  output logic [NUM_TMR-1:0] stat_o,
  output logic [NUM_TMR-1:0] mask_o,
  output logic               irq_o
);

  logic [NUM_TMR-1:0] stat_q, mask_q, clr_w;

  assign clr_w = ack_we_i ? ack_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      // a new expiry outranks a simultaneous acknowledge
      stat_q <= (stat_q & ~clr_w) | expire_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);

endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
  import dtmr_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] div_i,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_i,
  input  logic [NUM_TMR-1:0][CTRL_W-1:0] ctrl_i,
  input  logic [NUM_TMR-1:0]             stat_i,
  input  logic [NUM_TMR-1:0]             mask_i,
  output logic [DATA_W-1:0]              rdata_o
);

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (addr_i == ADDR_W'(t*TMR_STRIDE + OFS_DIV))  rdata_o = div_i[t];
      if (addr_i == ADDR_W'(t*TMR_STRIDE + OFS_CNT))  rdata_o = cnt_i[t];
      if (addr_i == ADDR_W'(t*TMR_STRIDE + OFS_CTRL)) rdata_o[CTRL_W-1:0] = ctrl_i[t];
    end
    if (addr_i == ADDR_W'(OFS_MASK))  rdata_o[NUM_TMR-1:0] = mask_i;
    if (addr_i == ADDR_W'(OFS_STAT))  rdata_o[NUM_TMR-1:0] = stat_i;
    if (addr_i == ADDR_W'(OFS_MSTAT)) rdata_o[NUM_TMR-1:0] = stat_i & mask_i;
  end

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int N_TICK  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_TICK-1:0] tick_i,
  output logic              irq_o
);

  logic [NUM_TMR-1:0][DATA_W-1:0] div_w, cnt_q;
  logic [NUM_TMR-1:0][CTRL_W-1:0] ctrl_w;
  logic [NUM_TMR-1:0]             expire_w, stat_q, mask_w;
  logic                           mask_we, ack_we;

  assign mask_we = bus_we_i && (bus_addr_i == ADDR_W'(OFS_MASK));
  assign ack_we  = bus_we_i && (bus_addr_i == ADDR_W'(OFS_ACK));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chan
    logic div_we, ctrl_we;
    assign div_we  = bus_we_i && (bus_addr_i == ADDR_W'(t*TMR_STRIDE + OFS_DIV));
    assign ctrl_we = bus_we_i && (bus_addr_i == ADDR_W'(t*TMR_STRIDE + OFS_CTRL));

    dtmr_chan #(
      .DATA_W (DATA_W),
      .N_TICK (N_TICK)
    ) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .div_we_i     (div_we),
      .ctrl_we_i    (ctrl_we),
      .div_wdata_i  (bus_wdata_i),
      .ctrl_wdata_i (bus_wdata_i[CTRL_W-1:0]),
      .tick_i       (tick_i),
      .div_o        (div_w[t]),
      .cnt_o        (cnt_q[t]),
      .ctrl_o       (ctrl_w[t]),
      .expire_o     (expire_w[t])
    );
  end

  dtmr_irq #(
    .NUM_TMR (NUM_TMR)
  ) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (mask_we),
    .mask_wdata_i (bus_wdata_i[NUM_TMR-1:0]),
    .ack_we_i     (ack_we),
    .ack_wdata_i  (bus_wdata_i[NUM_TMR-1:0]),
    .expire_i     (expire_w),
    .stat_o       (stat_q),
    .mask_o       (mask_w),
    .irq_o        (irq_o)
  );

  dtmr_rdmux #(
    .NUM_TMR (NUM_TMR),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_rdmux (
    .addr_i  (bus_addr_i),
    .div_i   (div_w),
    .cnt_i   (cnt_q),
    .ctrl_i  (ctrl_w),
    .stat_i  (stat_q),
    .mask_i  (mask_w),
    .rdata_o (bus_rdata_o)
  );

endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dtmr_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int N_TICK  = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           bus_we_i,
  input logic [ADDR_W-1:0]              bus_addr_i,
  input logic [DATA_W-1:0]              bus_wdata_i,
  input logic [N_TICK-1:0]              tick_i,
  input logic                           irq_o,
  input logic [NUM_TMR-1:0][DATA_W-1:0] cnt_i,
  input logic [NUM_TMR-1:0]             stat_i
);

  assert_irq_low_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !irq_o);

  assert_idle_counts_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i == '0 && !bus_we_i) |=> $stable(cnt_i));

  assert_no_status_without_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i == '0) |=> ((stat_i & ~$past(stat_i)) == '0));

  assert_full_ack_drops_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFS_ACK) && (&bus_wdata_i[NUM_TMR-1:0])
     && tick_i == '0) |=> !irq_o);

  assert_mask_clear_drops_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFS_MASK) && bus_wdata_i[NUM_TMR-1:0] == '0)
    |=> !irq_o);

endmodule

bind dual_timer dual_timer_chk #(
  .NUM_TMR (NUM_TMR),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .N_TICK  (N_TICK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .tick_i      (tick_i),
  .irq_o       (irq_o),
  .cnt_i       (cnt_q),
  .stat_i      (stat_q)
);

// File: tb/tb_dual_timer.sv
module tb_dual_timer;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [3:0]  tick_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk_i = ~clk_i;

  dual_timer dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .tick_i      (tick_i),
    .irq_o       (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] tk = 4'b0);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; tick_i = tk;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_addr_i = 8'h3C; bus_wdata_i = '0; tick_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic pulse(input logic [3:0] tk);
    @(negedge clk_i);
    tick_i = tk;
    @(negedge clk_i);
    tick_i = '0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk_i);
    #1 chk(tag, {31'b0, irq_o}, {31'b0, exp});
  endtask

  task automatic t_reset;
    chk_rd("R1 cnt0", 8'h04, 0);
    chk_rd("R1 cnt1", 8'h14, 0);
    chk_rd("R1 div0", 8'h00, 0);
    chk_rd("R1 ctrl1", 8'h18, 0);
    chk_rd("R1 status", 8'h50, 0);
    chk_rd("R1 mask", 8'h48, 0);
    chk_irq("R1 irq", 1'b0);
  endtask

  task automatic t_load;
    wr(8'h00, 5);
    chk_rd("R2 div write leaves count", 8'h04, 0);
    wr(8'h08, 32'h10);
    chk_rd("R2 load copies divisor", 8'h04, 5);
  endtask

  task automatic t_run;
    wr(8'h08, 32'h12);
    pulse(4'b0001);
    pulse(4'b0001);
    chk_rd("R3 two ticks", 8'h04, 3);
    pulse(4'b1110);
    chk_rd("R3 other sources ignored", 8'h04, 3);
  endtask

  task automatic t_hold;
    wr(8'h08, 32'h11);
    pulse(4'b1111);
    chk_rd("R4 hold freezes", 8'h04, 3);
  endtask

  task automatic t_src_off;
    wr(8'h08, 32'h06);
    pulse(4'b1111);
    chk_rd("R5 source code 1 no count", 8'h04, 3);
  endtask

  task automatic t_illegal;
    wr(8'h08, 32'h13);
    chk_rd("R6 ctrl unchanged", 8'h08, 32'h06);
    pulse(4'b0001);
    chk_rd("R6 count unchanged", 8'h04, 3);
  endtask

  task automatic t_expire;
    wr(8'h10, 2);
    wr(8'h18, 32'h14);
    wr(8'h18, 32'h16);
    pulse(4'b0010);
    chk_rd("R7 timer1 one tick", 8'h14, 1);
    chk_rd("R7 no early status", 8'h50, 0);
    pulse(4'b0010);
    chk_rd("R7 reload on expiry", 8'h14, 2);
    chk_rd("R7 timer1 sets bit1", 8'h50, 2);
    chk_irq("R10 masked off irq low", 1'b0);
  endtask

  task automatic t_mask;
    wr(8'h48, 3);
    chk_rd("R9 mask readback", 8'h48, 3);
    chk_rd("R9 masked status", 8'h54, 2);
    chk_irq("R10 irq high", 1'b1);
    wr(8'h48, 1);
    chk_rd("R9 masked status zero", 8'h54, 0);
    chk_irq("R10 irq low after mask", 1'b0);
  endtask

  task automatic t_ack;
    wr(8'h48, 3);
    wr(8'h00, 1);
    wr(8'h08, 32'h10);
    pulse(4'b0001);
    chk_rd("R7 timer0 sets bit0", 8'h50, 3);
    wr(8'h4C, 1);
    chk_rd("R8 ack clears bit0 only", 8'h50, 2);
    chk_irq("R10 irq still high", 1'b1);
    chk_rd("R8 ack reads zero", 8'h4C, 0);
    wr(8'h4C, 2);
    chk_rd("R8 ack clears bit1", 8'h50, 0);
    chk_irq("R10 irq low after ack", 1'b0);
  endtask

  task automatic t_unmapped;
    wr(8'h20, 32'hFFFF_FFFF);
    chk_rd("R11 unmapped read", 8'h20, 0);
    chk_rd("R11 unmapped 0x38", 8'h38, 0);
    wr(8'h50, 3);
    chk_rd("R11 status not writable", 8'h50, 0);
    chk_rd("R11 count intact", 8'h04, 1);
  endtask

  task automatic t_load_wins;
    wr(8'h00, 7);
    chk_rd("R2 div write while running", 8'h04, 1);
    wr(8'h08, 32'h10, 4'b0001);
    chk_rd("R12 load beats tick", 8'h04, 7);
    chk_rd("R12 no expiry", 8'h50, 0);
  endtask

  task automatic t_set_wins;
    wr(8'h00, 1);
    wr(8'h08, 32'h10);
    wr(8'h4C, 1, 4'b0001);
    chk_rd("R13 expiry beats ack", 8'h50, 1);
    chk_irq("R13 irq high", 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_load();
    t_run();
    t_hold();
    t_src_off();
    t_illegal();
    t_expire();
    t_mask();
    t_ack();
    t_unmapped();
    t_load_wins();
    t_set_wins();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule